// File: doc/BRIEF.md
# Masked Packed Int64-to-Float32 Converter

This block turns a vector of signed 64-bit integers into a vector of single-precision floating-point values. The output vector is half the width of the input. The source vector is 128, 256 or 512 bits long, which gives 2, 4 or 8 lanes. A per-lane writemask decides which lanes receive a new result. Each masked-off lane either keeps its previous destination contents or is cleared. A broadcast flag makes every lane convert the lowest source element.

Rounding normally follows a global 2-bit mode. An explicit per-operation override is honoured only in the 512-bit form. The block reports two things: an inexact flag covering the active lanes, and a fault for a malformed reserved operand field. When that fault is raised, the destination is left unchanged.

An operation is presented with a one-cycle `in_valid` strobe. The registered result appears on the next clock together with `out_valid`, and it is held until the next strobe.

Top module: `i64f32_cvt`

## Requirements
- R1: `vlen_sel` picks the lane count: 00 gives 2 lanes, 01 gives 4 lanes, and 10 or 11 give 8 lanes. Lane j converts `src_vec[64j+63:64j]` into `dst_vec[32j+31:32j]`.
- R2: Each integer is read as two's complement and rounded to a 24-bit significand. The 2-bit rounding mode is encoded as 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. A significand that rounds up to 2^24 carries into the exponent.
- R3: A lane inside the vector length is active when its `wmask` bit is 1 or `wmask_en` is 0. An active lane receives its converted value.
- R4: An inactive lane inside the vector length takes the matching 32 bits of `old_dst` when `zero_fill` is 0, and takes zero when `zero_fill` is 1.
- R5: Every `dst_vec` bit from 32 times the lane count up to bit 511 is 0, whatever the mask says.
- R6: When `bcast_en` is 1, every active lane converts `src_vec[63:0]` and ignores its own element.
- R7: `rnd_ovr_mode` is used when `rnd_ovr_en` is 1 and the length is 512 bits (`vlen_sel` 10 or 11). In every other case `rnd_glb_mode` is used.
- R8: `inexact` is the OR of the per-lane precision losses over active lanes only. Masked-off lanes never set it, and neither do lanes beyond the vector length.
- R9: When `rsvd_field` is not 4'b1111, the block raises `bad_enc`, copies `old_dst` to `dst_vec` unchanged and clears `inexact`. When the field is 4'b1111, `bad_enc` is 0.
- R10: `out_valid` is 1 exactly one cycle after `in_valid`. Outputs change only in that cycle. After reset all outputs are 0.
- R11: An input of 0 gives +0.0 (32'h0). The input -2^63 gives 32'hDF000000 and does not set `inexact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 512 | Packed signed 64-bit source elements |
| old_dst | input | 512 | Previous destination contents |
| vlen_sel | input | 2 | Vector length select |
| wmask | input | 8 | Per-lane writemask |
| wmask_en | input | 1 | Writemask enable |
| zero_fill | input | 1 | 1: masked lanes cleared, 0: masked lanes merged |
| bcast_en | input | 1 | Broadcast lowest source element |
| rnd_ovr_en | input | 1 | Request the explicit rounding override |
| rnd_ovr_mode | input | 2 | Override rounding mode |
| rnd_glb_mode | input | 2 | Global rounding mode |
| rsvd_field | input | 4 | Reserved operand field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| dst_vec | output | 512 | Destination vector |
| inexact | output | 1 | Precision lost in some active lane |
| bad_enc | output | 1 | Invalid-encoding fault |

## Verification
The hardest cases to reach are the rounding corners: a tie that goes to even, a round-up whose significand carries into the exponent, and the difference between directed modes on positive and negative values. Reaching them from the ports needs integers with exactly chosen low bits. The stimulus uses 2^24+1, 2^24+3, -(2^24+1) and 2^63-1, side by side in four lanes, and sweeps all four modes. Override gating is visible only by contrast, so the same lane value is sent at 256 and 512 bits with the override set in both.

// File: rtl/i64f32_pkg.sv
package i64f32_pkg;

    localparam int INT_W     = 64;
    localparam int EXP_W     = 8;
    localparam int MAN_W     = 23;
    localparam int FP_W      = 1 + EXP_W + MAN_W;
    localparam int EXP_BIAS  = 127;
    localparam int MAX_LANES = 8;
    localparam int DST_W     = 512;
    localparam int POS_W     = $clog2(INT_W);
    localparam int LCNT_W    = $clog2(MAX_LANES + 1);
    localparam logic [3:0] RSVD_OK = 4'b1111;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        VL_128  = 2'b00,
        VL_256  = 2'b01,
        VL_512  = 2'b10,
        VL_512X = 2'b11
    } vlen_e;

    typedef struct packed {
        logic [FP_W-1:0] bits;
        logic            inexact;
    } lane_res_t;

    function automatic logic [LCNT_W-1:0] lanes_for(vlen_e v);
        case (v)
            VL_128:  return LCNT_W'(MAX_LANES / 4);
            VL_256:  return LCNT_W'(MAX_LANES / 2);
            default: return LCNT_W'(MAX_LANES);
        endcase
    endfunction

    function automatic logic is_full_len(vlen_e v);
        return (v == VL_512) || (v == VL_512X);
    endfunction

    // Position of the highest set bit; 0 for a zero input.
    function automatic logic [POS_W-1:0] top_one_pos(logic [INT_W-1:0] v);
        logic [POS_W-1:0] p;
        p = '0;
        for (int b = 0; b < INT_W; b++) begin
            if (v[b]) p = POS_W'(b);
        end
        return p;
    endfunction

endpackage

// File: rtl/i64f32_rmsel.sv
module i64f32_rmsel
    import i64f32_pkg::*;
(
    input  vlen_e      vsel,
    input  logic       ovr_en,
    input  logic [1:0] ovr_mode,
    input  logic [1:0] glb_mode,
    output rnd_mode_e  mode
);
    always_comb begin
        if (ovr_en && is_full_len(vsel)) mode = rnd_mode_e'(ovr_mode);
        else                             mode = rnd_mode_e'(glb_mode);
    end
endmodule

// File: rtl/i64f32_lane.sv
module i64f32_lane
    import i64f32_pkg::*;
#(
    parameter int IW   = INT_W,
    parameter int EW   = EXP_W,
    parameter int MW   = MAN_W,
    parameter int BIAS = EXP_BIAS
) (
    input  logic [IW-1:0] value,
    input  rnd_mode_e     mode,
    output lane_res_t     res
);
    localparam int SIG_W = MW + 1;
    localparam int LOW_W = IW - SIG_W - 1;
    localparam int PW    = $clog2(IW);

    logic          neg;
    logic [IW-1:0] mag;
    logic [IW-1:0] norm;
    logic [PW-1:0] msb;
    logic [PW-1:0] shamt;
    logic [SIG_W-1:0] sig;
    logic          guard;
    logic          sticky;
    logic          bump;
    logic [SIG_W:0] sig_r;
    logic [EW-1:0] expo;

    always_comb begin
        neg    = value[IW-1];
        mag    = neg ? (~value + 1'b1) : value;
        msb    = top_one_pos(mag);
        shamt  = PW'(IW - 1) - msb;
        norm   = mag << shamt;
        sig    = norm[IW-1 -: SIG_W];
        guard  = norm[LOW_W];
        sticky = |norm[LOW_W-1:0];
        case (mode)
            RM_NEAR: bump = guard & (sticky | sig[0]);
            RM_DOWN: bump = neg & (guard | sticky);
            RM_UP:   bump = ~neg & (guard | sticky);
            RM_ZERO: bump = 1'b0;
        endcase
        sig_r = {1'b0, sig} + (SIG_W+1)'(bump);
        expo  = EW'(BIAS) + EW'(msb) + EW'(sig_r[SIG_W]);
        if (mag == '0) begin
            res.bits    = '0;
            res.inexact = 1'b0;
        end else begin
            // on carry the mantissa field is already all zero
            res.bits    = {neg, expo, sig_r[MW-1:0]};
            res.inexact = guard | sticky;
        end
    end
endmodule

// File: rtl/i64f32_lanectl.sv
module i64f32_lanectl
    import i64f32_pkg::*;
#(
    parameter int W = FP_W
) (
    input  logic         lane_on,
    input  logic         mask_bit,
    input  logic         mask_en,
    input  logic         zero_fill,
    input  logic [W-1:0] conv,
    input  logic         conv_inx,
    input  logic [W-1:0] old_word,
    output logic [W-1:0] word,
    output logic         inx
);
    logic active;

    always_comb begin
        active = lane_on & (mask_bit | ~mask_en);
        if (!lane_on)      word = '0;
        else if (active)   word = conv;
        else if (zero_fill) word = '0;
        else               word = old_word;
        inx = active & conv_inx;
    end
endmodule

// File: rtl/i64f32_cvt.sv
module i64f32_cvt
    import i64f32_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    parameter int IW    = INT_W,
    parameter int OW    = FP_W,
    parameter int DW    = DST_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LANES*IW-1:0] src_vec,
    input  logic [DW-1:0]    old_dst,
    input  logic [1:0]       vlen_sel,
    input  logic [LANES-1:0] wmask,
    input  logic             wmask_en,
    input  logic             zero_fill,
    input  logic             bcast_en,
    input  logic             rnd_ovr_en,
    input  logic [1:0]       rnd_ovr_mode,
    input  logic [1:0]       rnd_glb_mode,
    input  logic [3:0]       rsvd_field,
    output logic             out_valid,
    output logic [DW-1:0]    dst_vec,
    output logic             inexact,
    output logic             bad_enc
);
    localparam int PACK_W  = LANES * OW;
    localparam int UPPER_W = DW - PACK_W;

    vlen_e             vsel;
    rnd_mode_e         eff_mode;
    logic [LCNT_W-1:0] lane_cnt;
    logic [PACK_W-1:0] packed_res;
    logic [LANES-1:0]  lane_inx;
    logic              enc_ok;

    assign vsel     = vlen_e'(vlen_sel);
    assign lane_cnt = lanes_for(vsel);
    assign enc_ok   = (rsvd_field == RSVD_OK);

    i64f32_rmsel u_rmsel (
        .vsel     (vsel),
        .ovr_en   (rnd_ovr_en),
        .ovr_mode (rnd_ovr_mode),
        .glb_mode (rnd_glb_mode),
        .mode     (eff_mode)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IW-1:0] elem;
        lane_res_t     conv;
        logic          on;

        assign elem = bcast_en ? src_vec[IW-1:0] : src_vec[j*IW +: IW];
        assign on   = (lane_cnt > LCNT_W'(j));

        i64f32_lane #(.IW(IW)) u_cvt (
            .value (elem),
            .mode  (eff_mode),
            .res   (conv)
        );

        i64f32_lanectl #(.W(OW)) u_ctl (
            .lane_on   (on),
            .mask_bit  (wmask[j]),
            .mask_en   (wmask_en),
            .zero_fill (zero_fill),
            .conv      (conv.bits),
            .conv_inx  (conv.inexact),
            .old_word  (old_dst[j*OW +: OW]),
            .word      (packed_res[j*OW +: OW]),
            .inx       (lane_inx[j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dst_vec   <= '0;
            inexact   <= 1'b0;
            bad_enc   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (enc_ok) begin
                    dst_vec <= {{UPPER_W{1'b0}}, packed_res};
                    inexact <= |lane_inx;
                    bad_enc <= 1'b0;
                end else begin
                    dst_vec <= old_dst;
                    inexact <= 1'b0;
                    bad_enc <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i64f32_chk.sv
module i64f32_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [511:0] src_vec,
    input logic [511:0] old_dst,
    input logic [1:0]   vlen_sel,
    input logic [7:0]   wmask,
    input logic         wmask_en,
    input logic         zero_fill,
    input logic         bcast_en,
    input logic [3:0]   rsvd_field,
    input logic         out_valid,
    input logic [511:0] dst_vec,
    input logic         inexact,
    input logic         bad_enc
);
    p_valid_next_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(dst_vec) && $stable(inexact)));

    p_upper_2lane_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field == 4'hF && vlen_sel == 2'b00) |=> dst_vec[511:64] == '0);

    p_upper_4lane_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field == 4'hF && vlen_sel == 2'b01) |=> dst_vec[511:128] == '0);

    p_upper_8lane_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field == 4'hF) |=> dst_vec[511:256] == '0);

    p_bad_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field != 4'hF) |=>
            (bad_enc && !inexact && dst_vec == $past(old_dst)));

    p_merge_lane0_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field == 4'hF && wmask_en && !wmask[0] && !zero_fill) |=>
            dst_vec[31:0] == $past(old_dst[31:0]));

    p_zero_lane0_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field == 4'hF && wmask_en && !wmask[0] && zero_fill) |=>
            dst_vec[31:0] == 32'h0);

    p_no_active_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && wmask_en && wmask == 8'h00) |=> !inexact);

    p_zero_in_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rsvd_field == 4'hF && !wmask_en && !bcast_en && src_vec[63:0] == 64'h0) |=>
            (dst_vec[31:0] == 32'h0));
endmodule

bind i64f32_cvt i64f32_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .src_vec    (src_vec),
    .old_dst    (old_dst),
    .vlen_sel   (vlen_sel),
    .wmask      (wmask),
    .wmask_en   (wmask_en),
    .zero_fill  (zero_fill),
    .bcast_en   (bcast_en),
    .rsvd_field (rsvd_field),
    .out_valid  (out_valid),
    .dst_vec    (dst_vec),
    .inexact    (inexact),
    .bad_enc    (bad_enc)
);

// File: tb/sim_i64f32_cvt.sv
module sim_i64f32_cvt;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [511:0] old_dst = '0;
    logic [1:0]   vlen_sel = 2'b10;
    logic [7:0]   wmask = '0;
    logic         wmask_en = 1'b0;
    logic         zero_fill = 1'b0;
    logic         bcast_en = 1'b0;
    logic         rnd_ovr_en = 1'b0;
    logic [1:0]   rnd_ovr_mode = 2'b00;
    logic [1:0]   rnd_glb_mode = 2'b00;
    logic [3:0]   rsvd_field = 4'hF;
    logic         out_valid;
    logic [511:0] dst_vec;
    logic         inexact;
    logic         bad_enc;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [63:0] I_P1    = 64'd1;
    localparam logic [63:0] I_M1    = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] I_P2    = 64'd2;
    localparam logic [63:0] I_MIN   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] I_P3    = 64'd3;
    localparam logic [63:0] I_4096  = 64'd4096;
    localparam logic [63:0] I_M5    = 64'hFFFF_FFFF_FFFF_FFFB;
    localparam logic [63:0] I_ZERO  = 64'd0;
    localparam logic [63:0] I_T1    = 64'd16777217;
    localparam logic [63:0] I_NT1   = 64'hFFFF_FFFF_FEFF_FFFF;
    localparam logic [63:0] I_T3    = 64'd16777219;
    localparam logic [63:0] I_MAX   = 64'h7FFF_FFFF_FFFF_FFFF;

    localparam logic [31:0] F_P1   = 32'h3F80_0000;
    localparam logic [31:0] F_M1   = 32'hBF80_0000;
    localparam logic [31:0] F_P2   = 32'h4000_0000;
    localparam logic [31:0] F_MIN  = 32'hDF00_0000;
    localparam logic [31:0] F_P3   = 32'h4040_0000;
    localparam logic [31:0] F_4096 = 32'h4580_0000;
    localparam logic [31:0] F_M5   = 32'hC0A0_0000;

    localparam logic [511:0] OLD_PAT = {16{32'hA5C3_0F1E}};

    i64f32_cvt u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .src_vec (src_vec), .old_dst (old_dst), .vlen_sel (vlen_sel),
        .wmask (wmask), .wmask_en (wmask_en), .zero_fill (zero_fill),
        .bcast_en (bcast_en), .rnd_ovr_en (rnd_ovr_en),
        .rnd_ovr_mode (rnd_ovr_mode), .rnd_glb_mode (rnd_glb_mode),
        .rsvd_field (rsvd_field), .out_valid (out_valid),
        .dst_vec (dst_vec), .inexact (inexact), .bad_enc (bad_enc)
    );

    always #2 clk = ~clk;

    task automatic cmp(string tag, logic [511:0] act, logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected destination from lane count, mask settings and per-lane results
    function automatic logic [511:0] model(int nl, logic [7:0] m, logic men, logic zf,
                                           logic [255:0] conv, logic [511:0] old);
        logic [511:0] r;
        r = '0;
        for (int j = 0; j < nl; j++) begin
            if (!men || m[j])  r[32*j +: 32] = conv[32*j +: 32];
            else if (!zf)      r[32*j +: 32] = old[32*j +: 32];
        end
        return r;
    endfunction

    task automatic issue(logic [1:0] vl, logic [7:0] m, logic men, logic zf, logic bc,
                         logic oen, logic [1:0] om, logic [1:0] gm, logic [3:0] rsv,
                         logic [511:0] s, logic [511:0] old);
        @(negedge clk);
        vlen_sel = vl; wmask = m; wmask_en = men; zero_fill = zf; bcast_en = bc;
        rnd_ovr_en = oen; rnd_ovr_mode = om; rnd_glb_mode = gm; rsvd_field = rsv;
        src_vec = s; old_dst = old; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        cmp("R10 out_valid after strobe", {511'b0, out_valid}, 512'd1);
    endtask

    task automatic t_reset();
        cmp("R10 reset out_valid", {511'b0, out_valid}, '0);
        cmp("R10 reset dst", dst_vec, '0);
        cmp("R10 reset flags", {510'b0, inexact, bad_enc}, '0);
    endtask

    task automatic t_basic();
        logic [511:0] s;
        logic [255:0] c;
        s = {256'h0, I_ZERO, I_M5, I_4096, I_P3, I_MIN, I_P2, I_M1, I_P1};
        s[511:256] = {I_P1, I_P1, I_P1, I_P1};
        s = {I_P1, I_P1, I_P1, I_P1, s[255:0]};
        s = {I_ZERO, I_M5, I_4096, I_P3, I_MIN, I_P2, I_M1, I_P1};
        c = {32'h0, F_M5, F_4096, F_P3, F_MIN, F_P2, F_M1, F_P1};
        issue(2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R1 R2 R11 eight-lane conversion", dst_vec, model(8, 8'h0, 1'b0, 1'b0, c, OLD_PAT));
        cmp("R11 exact values leave inexact clear", {511'b0, inexact}, '0);
        cmp("R9 good field no fault", {511'b0, bad_enc}, '0);
    endtask

    task automatic t_hold();
        logic [511:0] snap;
        snap = dst_vec;
        @(negedge clk);
        src_vec = '1; old_dst = '0;
        repeat (3) @(posedge clk);
        #1;
        cmp("R10 idle out_valid low", {511'b0, out_valid}, '0);
        cmp("R10 idle dst held", dst_vec, snap);
    endtask

    task automatic t_vlen();
        logic [511:0] s;
        logic [255:0] c;
        s = {I_P1, I_M1, I_P2, I_P3, I_4096, I_M5, I_P2, I_P1};
        c = {F_P1, F_M1, F_P2, F_P3, F_4096, F_M5, F_P2, F_P1};
        issue(2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, '1);
        cmp("R1 R5 two lanes, upper cleared", dst_vec, model(2, 8'h0, 1'b0, 1'b0, c, '1));
        issue(2'b01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, '1);
        cmp("R1 R5 four lanes, upper cleared", dst_vec, model(4, 8'h0, 1'b0, 1'b0, c, '1));
        issue(2'b11, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, '1);
        cmp("R1 R5 select 11 gives eight lanes", dst_vec, model(8, 8'h0, 1'b0, 1'b0, c, '1));
    endtask

    task automatic t_mask();
        logic [511:0] s;
        logic [255:0] c;
        s = {I_M5, I_4096, I_P3, I_MIN, I_P2, I_M1, I_P1, I_P3};
        c = {F_M5, F_4096, F_P3, F_MIN, F_P2, F_M1, F_P1, F_P3};
        issue(2'b10, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R3 R4 merge masking", dst_vec, model(8, 8'hA5, 1'b1, 1'b0, c, OLD_PAT));
        issue(2'b10, 8'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R3 R4 zeroing masking", dst_vec, model(8, 8'h5A, 1'b1, 1'b1, c, OLD_PAT));
        issue(2'b01, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R3 mask ignored when disabled", dst_vec, model(4, 8'h0, 1'b0, 1'b1, c, OLD_PAT));
    endtask

    task automatic t_bcast();
        logic [511:0] s;
        s = {I_M5, I_4096, I_MIN, I_P2, I_M1, I_P1, I_M5, I_P3};
        issue(2'b10, 8'h6D, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R6 broadcast of element zero", dst_vec,
            model(8, 8'h6D, 1'b1, 1'b0, {8{F_P3}}, OLD_PAT));
    endtask

    task automatic t_round();
        logic [511:0] s;
        logic [127:0] e [4];
        s = {256'h0, I_MAX, I_T3, I_NT1, I_T1};
        e[0] = {32'h5F00_0000, 32'h4B80_0002, 32'hCB80_0000, 32'h4B80_0000};
        e[1] = {32'h5EFF_FFFF, 32'h4B80_0001, 32'hCB80_0001, 32'h4B80_0000};
        e[2] = {32'h5F00_0000, 32'h4B80_0002, 32'hCB80_0000, 32'h4B80_0001};
        e[3] = {32'h5EFF_FFFF, 32'h4B80_0001, 32'hCB80_0000, 32'h4B80_0000};
        for (int m = 0; m < 4; m++) begin
            issue(2'b01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'(m), 4'hF, s, OLD_PAT);
            cmp($sformatf("R2 rounding mode %0d", m), dst_vec, {384'h0, e[m]});
            cmp($sformatf("R8 inexact mode %0d", m), {511'b0, inexact}, 512'd1);
        end
    endtask

    task automatic t_ovr();
        logic [511:0] s;
        s = {448'h0, I_T1};
        issue(2'b01, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R7 override ignored below 512", dst_vec, {480'h0, 32'h4B80_0000});
        issue(2'b10, 8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R7 override used at 512", dst_vec, {480'h0, 32'h4B80_0001});
        issue(2'b10, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R7 global used when override off", dst_vec, {480'h0, 32'h4B80_0000});
    endtask

    task automatic t_inexact_mask();
        logic [511:0] s;
        s = {I_P1, I_P1, I_P1, I_P1, I_P1, I_P1, I_P1, I_T1};
        issue(2'b10, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R8 masked lane does not set inexact", {511'b0, inexact}, '0);
        issue(2'b10, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R8 active lane sets inexact", {511'b0, inexact}, 512'd1);
        s = {I_P1, I_P1, I_T1, I_P1, I_P1, I_P1, I_P1, I_P1};
        issue(2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, s, OLD_PAT);
        cmp("R8 lane beyond length does not set inexact", {511'b0, inexact}, '0);
    endtask

    task automatic t_badenc();
        logic [511:0] s;
        s = {8{I_T1}};
        issue(2'b10, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 4'hE, s, OLD_PAT);
        cmp("R9 fault raised", {511'b0, bad_enc}, 512'd1);
        cmp("R9 destination unchanged", dst_vec, OLD_PAT);
        cmp("R9 inexact clear on fault", {511'b0, inexact}, '0);
        issue(2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 4'hF, {8{I_P1}}, OLD_PAT);
        cmp("R9 fault clears on good field", {511'b0, bad_enc}, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_hold();
        t_vlen();
        t_mask();
        t_bcast();
        t_round();
        t_ovr();
        t_inexact_mask();
        t_badenc();
        repeat (2) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule